// File: doc/BRIEF.md
# Smart-Card T=0 Character Receiver with Error Signalling

This block receives characters from the shared, idle-high I/O line of a smart-card link running the T=0 character protocol. A character is a low start bit, eight data bits sent least significant bit first, and an even parity bit. Two bit times of guard follow, during which the sender leaves the line alone. The receiver runs from a sample strobe that arrives `TICKS_PER_BIT` times per bit. It finds the start bit on a falling edge and samples every bit at its middle.

A character with correct parity is handed out as a one-cycle strobe with the byte. A character with a parity fault is held back, and the receiver tells the sender by pulling the line low for one bit time at the start of the guard time. The `io_drive_low` output asks the pad to pull the line low, so the line behaves as a wired-AND. A mode input suppresses that pull and raises a separate sticky flag instead.

Every parity fault also steps an 8-bit error counter. The counter stops at its maximum and is cleared by a read strobe.

Top module: `iso_t0_rx`

## Requirements
- R1: A start is recognised on a sample tick that sees the line low after a tick that saw it high. The line must still be low half a bit time later. A low pulse shorter than half a bit time produces no output and no error.
- R2: The character format is a start bit, eight data bits least significant first, one parity bit equal to the XOR of the eight data bits (even parity), and then two guard bit times. A character with correct parity gives a `rx_valid` pulse one clock wide, with the byte on `rx_data` in that clock.
- R3: A character with a parity fault never gives `rx_valid`. It sets `parity_err_flag`, which stays at 1 until `clr_parity` is pulsed.
- R4: After a parity fault with `nack_inhibit` at 0, `io_drive_low` is 1 for exactly one bit time (`TICKS_PER_BIT` sample ticks), starting at the first guard bit. It is back at 0 within the second guard bit.
- R5: After a parity fault with `nack_inhibit` at 1, `io_drive_low` stays 0 and `nack_inhibited_flag` is set.
- R6: `clr_nack` clears `nack_inhibited_flag`, and `clr_parity` clears `parity_err_flag`. If a new fault arrives in the same clock as a clear, the flag ends up set.
- R7: `err_count` rises by one for each parity fault. It holds at 255 instead of wrapping to 0.
- R8: A `cnt_read` pulse makes `err_count` 0 in the next clock. If a fault is counted in the same clock as the read, `err_count` becomes 1.
- R9: The falling edge caused by the receiver's own error pull is not taken as a start bit. A character whose start begins right after the two guard bit times is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Sample strobe, `TICKS_PER_BIT` pulses per bit time |
| io_in | input | 1 | Level of the shared I/O line (asynchronous) |
| nack_inhibit | input | 1 | 1: do not pull the line on a parity fault |
| clr_parity | input | 1 | Clear pulse for the parity-fault flag |
| clr_nack | input | 1 | Clear pulse for the inhibited-error flag |
| cnt_read | input | 1 | Read strobe for the error counter (clears it) |
| rx_data | output | 8 | Last byte received with correct parity |
| rx_valid | output | 1 | One-clock strobe for a good byte |
| io_drive_low | output | 1 | 1: pull the I/O line to 0 |
| err_count | output | 8 | Saturating count of parity faults |
| parity_err_flag | output | 1 | Sticky parity-fault flag |
| nack_inhibited_flag | output | 1 | Sticky flag: a fault occurred while the pull was suppressed |

## Verification
The assertions assume that `sample_tick` arrives at most once every few clocks. This leaves room for the line synchroniser to settle between ticks. They also assume that the flag clears are not pulsed between a fault and the start of its error pull, since the pull checks that the parity flag is set. The bench generates the tick every third clock. It holds each bit for exactly four ticks and changes the line one time unit after a tick edge. It pulses the clears only after a character has finished, and it models the line as the AND of its own drive and the receiver's pull.

// File: rtl/iso_t0_rx_pkg.sv
package iso_t0_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_BITS  = 2'd2,
      ST_GUARD = 2'd3
   } rx_state_e;
endpackage

// File: rtl/t0_line_sync.sv
module t0_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0:0], din} >> ((STAGES == 1) ? 1 : 0);
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/t0_sticky_flag.sv
module t0_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/t0_err_counter.sv
module t0_err_counter #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd_clr,
   output logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] MAXV = '1;
   logic [WIDTH-1:0] base;
   logic [WIDTH-1:0] nxt;

   always_comb begin
      base = rd_clr ? '0 : count;
      nxt  = base;
      if (inc && base != MAXV) nxt = base + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end
endmodule

// File: rtl/t0_frame_rx.sv
module t0_frame_rx
   import iso_t0_rx_pkg::*;
#(
   parameter int DATA_BITS     = 8,
   parameter int TICKS_PER_BIT = 8,
   parameter int GUARD_BITS    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 line,
   input  logic                 inhibit,
   output logic [DATA_BITS-1:0] data,
   output logic                 data_valid,
   output logic                 par_err,
   output logic                 nack_blocked,
   output logic                 drive_low
);
   localparam int HALF   = TICKS_PER_BIT / 2;
   localparam int GSPAN  = GUARD_BITS * TICKS_PER_BIT;
   localparam int CW     = $clog2(GSPAN + 1);
   localparam int BW     = $clog2(DATA_BITS + 1);
   localparam logic [CW-1:0] HALF_M1  = CW'(HALF - 1);
   localparam logic [CW-1:0] BIT_M1   = CW'(TICKS_PER_BIT - 1);
   localparam logic [CW-1:0] DREL_M1  = CW'(HALF + TICKS_PER_BIT - 1);
   localparam logic [CW-1:0] GEND_M1  = CW'(GSPAN - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS);

   rx_state_e           st;
   logic [CW-1:0]       tcnt;
   logic [BW-1:0]       bidx;
   logic [DATA_BITS:0]  sh;
   logic [DATA_BITS:0]  sh_nxt;
   logic                prev_line;
   logic                nack_pend;

   assign sh_nxt = {line, sh[DATA_BITS:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         tcnt         <= '0;
         bidx         <= '0;
         sh           <= '0;
         prev_line    <= 1'b1;
         nack_pend    <= 1'b0;
         data         <= '0;
         data_valid   <= 1'b0;
         par_err      <= 1'b0;
         nack_blocked <= 1'b0;
         drive_low    <= 1'b0;
      end else begin
         data_valid   <= 1'b0;
         par_err      <= 1'b0;
         nack_blocked <= 1'b0;
         if (tick) prev_line <= line;
         case (st)
            ST_IDLE: begin
               if (tick && prev_line && !line) begin
                  st   <= ST_START;
                  tcnt <= '0;
               end
            end
            ST_START: begin
               if (tick) begin
                  if (tcnt == HALF_M1) begin
                     tcnt <= '0;
                     bidx <= '0;
                     st   <= line ? ST_IDLE : ST_BITS;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_BITS: begin
               if (tick) begin
                  if (tcnt == BIT_M1) begin
                     tcnt <= '0;
                     sh   <= sh_nxt;
                     bidx <= bidx + 1'b1;
                     if (bidx == LAST_BIT) begin
                        st <= ST_GUARD;
                        if (^sh_nxt) begin
                           par_err <= 1'b1;
                           if (inhibit) nack_blocked <= 1'b1;
                           else         nack_pend    <= 1'b1;
                        end else begin
                           data_valid <= 1'b1;
                           data       <= sh_nxt[DATA_BITS-1:0];
                        end
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_GUARD: begin
               if (tick) begin
                  tcnt <= tcnt + 1'b1;
                  if (tcnt == HALF_M1 && nack_pend) drive_low <= 1'b1;
                  if (tcnt == DREL_M1) begin
                     drive_low <= 1'b0;
                     nack_pend <= 1'b0;
                  end
                  if (tcnt == GEND_M1) begin
                     st   <= ST_IDLE;
                     tcnt <= '0;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/iso_t0_rx.sv
module iso_t0_rx #(
   parameter int DATA_BITS     = 8,
   parameter int TICKS_PER_BIT = 8,
   parameter int GUARD_BITS    = 2,
   parameter int CNT_WIDTH     = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sample_tick,
   input  logic                 io_in,
   input  logic                 nack_inhibit,
   input  logic                 clr_parity,
   input  logic                 clr_nack,
   input  logic                 cnt_read,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 io_drive_low,
   output logic [CNT_WIDTH-1:0] err_count,
   output logic                 parity_err_flag,
   output logic                 nack_inhibited_flag
);
   generate
      if (TICKS_PER_BIT < 4 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_tpb
         $error("TICKS_PER_BIT must be even and at least 4");
      end
      if (GUARD_BITS < 2) begin : g_bad_guard
         $error("GUARD_BITS must be at least 2");
      end
      if (DATA_BITS < 1 || CNT_WIDTH < 1 || SYNC_STAGES < 0) begin : g_bad_width
         $error("DATA_BITS and CNT_WIDTH must be positive, SYNC_STAGES non-negative");
      end
   endgenerate

   logic line_s;
   logic err_pulse;
   logic blk_pulse;

   t0_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(io_in), .dout(line_s)
   );

   t0_frame_rx #(
      .DATA_BITS(DATA_BITS), .TICKS_PER_BIT(TICKS_PER_BIT), .GUARD_BITS(GUARD_BITS)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line(line_s),
      .inhibit(nack_inhibit), .data(rx_data), .data_valid(rx_valid),
      .par_err(err_pulse), .nack_blocked(blk_pulse), .drive_low(io_drive_low)
   );

   t0_err_counter #(.WIDTH(CNT_WIDTH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(err_pulse), .rd_clr(cnt_read), .count(err_count)
   );

   t0_sticky_flag u_par_flag (
      .clk(clk), .rst_n(rst_n), .set(err_pulse), .clr(clr_parity), .q(parity_err_flag)
   );

   t0_sticky_flag u_nack_flag (
      .clk(clk), .rst_n(rst_n), .set(blk_pulse), .clr(clr_nack), .q(nack_inhibited_flag)
   );
endmodule

// File: rtl/iso_t0_rx_chk.sv
module iso_t0_rx_chk #(
   parameter int DATA_BITS     = 8,
   parameter int TICKS_PER_BIT = 8,
   parameter int CNT_WIDTH     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sample_tick,
   input logic                 clr_parity,
   input logic                 clr_nack,
   input logic                 cnt_read,
   input logic                 rx_valid,
   input logic                 io_drive_low,
   input logic [CNT_WIDTH-1:0] err_count,
   input logic                 parity_err_flag,
   input logic                 nack_inhibited_flag
);
   localparam logic [CNT_WIDTH-1:0] CMAX = '1;
   logic [15:0] drv_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            drv_ticks <= '0;
      else if (!io_drive_low) drv_ticks <= '0;
      else if (sample_tick)  drv_ticks <= drv_ticks + 16'd1;
   end

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   p_no_valid_in_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      io_drive_low |-> !rx_valid);
   p_par_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (parity_err_flag && !clr_parity) |=> parity_err_flag);
   p_nack_needs_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_drive_low) |-> parity_err_flag);
   p_nack_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(io_drive_low) |-> drv_ticks == 16'(TICKS_PER_BIT));
   p_blk_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (nack_inhibited_flag && !clr_nack) |=> nack_inhibited_flag);
   p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count == CMAX && !cnt_read) |=> err_count == CMAX);
   p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_read |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));
   p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_read |=> err_count <= 1);
endmodule

bind iso_t0_rx iso_t0_rx_chk #(
   .DATA_BITS(DATA_BITS), .TICKS_PER_BIT(TICKS_PER_BIT), .CNT_WIDTH(CNT_WIDTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .clr_parity(clr_parity),
   .clr_nack(clr_nack), .cnt_read(cnt_read), .rx_valid(rx_valid),
   .io_drive_low(io_drive_low), .err_count(err_count),
   .parity_err_flag(parity_err_flag), .nack_inhibited_flag(nack_inhibited_flag)
);

// File: tb/iso_t0_rx_test.sv
`timescale 1ns/1ps
module iso_t0_rx_test;
   localparam int TPB = 4;
   localparam int DIV = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   int   tdiv = 0;
   logic drv = 1'b1;
   logic nack_inhibit = 1'b0, clr_parity = 1'b0, clr_nack = 1'b0, cnt_read = 1'b0;
   logic [7:0] rx_data, err_count;
   logic rx_valid, io_drive_low, parity_err_flag, nack_inhibited_flag;
   logic io_line;

   int checks = 0, failures = 0;
   int exp_cnt = 0;
   int nack_len = 0;
   bit done = 0;
   logic [7:0] exp_q[$];

   assign io_line = drv & ~io_drive_low;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      tdiv <= (tdiv == DIV-1) ? 0 : tdiv + 1;
      tick <= (tdiv == DIV-1);
   end

   iso_t0_rx #(.TICKS_PER_BIT(TPB)) uut (
      .clk(clk), .rst_n(rst_n), .sample_tick(tick), .io_in(io_line),
      .nack_inhibit(nack_inhibit), .clr_parity(clr_parity), .clr_nack(clr_nack),
      .cnt_read(cnt_read), .rx_data(rx_data), .rx_valid(rx_valid),
      .io_drive_low(io_drive_low), .err_count(err_count),
      .parity_err_flag(parity_err_flag), .nack_inhibited_flag(nack_inhibited_flag)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (n) begin
         @(posedge clk);
         while (!tick) @(posedge clk);
      end
      #1;
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1;
      @(posedge clk); #1;
      s = 1'b0;
   endtask

   // Monitor: scoreboard for good bytes, and length of each error pull
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected rx_valid", rx_data, -1);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rx_data == e, "R2", "received byte", rx_data, e);
         end
      end
      if (rst_n && io_drive_low) nack_len++;
      else if (nack_len != 0) begin
         chk(nack_len == TPB*DIV, "R4", "error pull length in clocks", nack_len, TPB*DIV);
         nack_len = 0;
      end
   end

   // Driver: one character, optional parity fault, optional counter read at parity sample
   task automatic send_char(input logic [7:0] d, input bit bad, input bit rd_at_par);
      logic par;
      bit   exp_pull;
      par = (^d) ^ bad;
      exp_pull = bad && !nack_inhibit;
      if (!bad) exp_q.push_back(d);
      if (rd_at_par) exp_cnt = bad ? 1 : 0;
      else if (bad && exp_cnt < 255) exp_cnt++;
      wait_ticks(1);
      drv = 1'b0; wait_ticks(TPB);
      for (int i = 0; i < 8; i++) begin
         drv = d[i]; wait_ticks(TPB);
      end
      drv = par; wait_ticks(TPB-1);
      if (rd_at_par) pulse(cnt_read);
      wait_ticks(1);
      drv = 1'b1;
      wait_ticks(3);
      @(negedge clk);
      chk(io_drive_low == exp_pull, bad ? (nack_inhibit ? "R5" : "R4") : "R2",
          "pull in first guard bit", io_drive_low, exp_pull);
      wait_ticks(4);
      @(negedge clk);
      chk(io_drive_low == 1'b0, "R4", "pull released in second guard bit", io_drive_low, 0);
      wait_ticks(TPB);
   endtask

   task automatic short_glitch();
      wait_ticks(1);
      drv = 1'b0; wait_ticks(1);
      drv = 1'b1; wait_ticks(3*TPB);
   endtask

   task automatic check_count(input string req);
      @(negedge clk);
      chk(err_count == exp_cnt[7:0], req, "err_count", err_count, exp_cnt);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(rx_valid == 0 && io_drive_low == 0, "R2", "reset outputs idle", rx_valid + io_drive_low, 0);
      chk(err_count == 0, "R7", "reset count", err_count, 0);
      chk(parity_err_flag == 0 && nack_inhibited_flag == 0, "R3", "reset flags",
          parity_err_flag + nack_inhibited_flag, 0);

      // R1 R2: good characters of several patterns
      send_char(8'hA5, 0, 0);
      send_char(8'h00, 0, 0);
      send_char(8'hFF, 0, 0);
      send_char(8'h3C, 0, 0);
      send_char(8'h81, 0, 0);
      check_count("R2");
      chk(parity_err_flag == 0, "R2", "no parity flag on good data", parity_err_flag, 0);

      // R1: short low pulse dropped, next character fine
      short_glitch();
      chk(parity_err_flag == 0, "R1", "glitch raises no fault", parity_err_flag, 0);
      send_char(8'h5A, 0, 0);

      // R3 R4 R9: parity fault with error pull, then a good character right after
      send_char(8'h96, 1, 0);
      chk(parity_err_flag == 1, "R3", "parity flag set", parity_err_flag, 1);
      check_count("R7");
      send_char(8'h42, 0, 0);
      chk(exp_q.size() == 0, "R9", "byte after error pull received", exp_q.size(), 0);

      // R6: clear parity flag
      pulse(clr_parity);
      @(negedge clk);
      chk(parity_err_flag == 0, "R6", "parity flag cleared", parity_err_flag, 0);

      // R5 R6: inhibited error
      nack_inhibit = 1'b1;
      send_char(8'h11, 1, 0);
      chk(nack_inhibited_flag == 1, "R5", "inhibited flag set", nack_inhibited_flag, 1);
      chk(parity_err_flag == 1, "R3", "parity flag set when inhibited", parity_err_flag, 1);
      check_count("R7");
      pulse(clr_nack);
      @(negedge clk);
      chk(nack_inhibited_flag == 0, "R6", "inhibited flag cleared", nack_inhibited_flag, 0);
      chk(parity_err_flag == 1, "R6", "parity flag kept by other clear", parity_err_flag, 1);
      nack_inhibit = 1'b0;

      // R8: plain read
      check_count("R8");
      pulse(cnt_read);
      exp_cnt = 0;
      check_count("R8");

      // R8: read in same clock as a counted fault
      send_char(8'h7E, 1, 1);
      check_count("R8");

      // R7: saturation
      nack_inhibit = 1'b1;
      for (int k = 0; k < 256; k++) send_char(8'(k), 1, 0);
      check_count("R7");
      chk(err_count == 8'd255, "R7", "saturated at 255", err_count, 255);
      pulse(cnt_read);
      exp_cnt = 0;
      check_count("R8");
      nack_inhibit = 1'b0;

      send_char(8'hC3, 0, 0);
      repeat (4) @(posedge clk);
      chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule